// File: doc/BRIEF.md
# Dual-Bus Ready Synchronizer

This block merges the ready requests of several system buses into the single READY line of a processor. Each bus supplies a ready level and a gate. The gate decides whether that bus's ready counts at all. A bus whose gate sits at its active level (low by default) is always qualified, which is the single-master wiring. A qualified ready from any bus is enough to make the merged request true.

The merged request passes through two flip-flop stages, both clocked by the processor clock. Stage one captures on the rising edge and stage two on the falling edge. A mode input picks the path for each falling edge. In two-stage mode a request must first be seen by stage one and then by stage two. A withdrawn request reaches stage two directly, so READY drops at the next falling edge. In one-stage mode stage one is skipped, and stage two takes the merged request at every falling edge. The mode may be changed from one bus cycle to the next. Reset is asynchronous and active low, and it empties both stages.

Top module: `rdy_sync_dual`

## Requirements
- R1: Bus i is qualified only when bus_rdy[i] is 1 and bus_gate[i] is at its active level (0 with the default GATE_ACTIVE_LOW=1). A bus whose gate is inactive never raises ready_o.
- R2: The merged request is true when at least one bus is qualified, whichever bus that is.
- R3: With mode_sync=0, ready_o rises only at a falling edge that follows a rising edge at which the merged request was true, with the request still true at that falling edge. A request that first appears during the high phase raises ready_o one full clock later.
- R4: In either mode, ready_o is 0 after every falling edge at which the merged request is false. No rising edge is needed for this deassertion.
- R5: With mode_sync=1, ready_o after each falling edge equals the merged request sampled at that edge.
- R6: ready_o changes only at falling clock edges or on reset. It is constant across rising edges.
- R7: mode_sync is applied at each falling edge on its own, so a change of mode takes effect in the bus cycle where it occurs.
- R8: While rst_n is 0, ready_o is 0 and stage one is cleared. After release, two-stage mode needs a fresh rising-edge capture before ready_o can rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; both edges used |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rdy | input | N_REQ | Ready level of each bus |
| bus_gate | input | N_REQ | Per-bus qualifier, active low by default |
| mode_sync | input | 1 | 1: one-stage mode, 0: two-stage mode |
| ready_o | output | 1 | Synchronized READY to the processor |

## Verification
The case that is hardest to reach from the ports is a request that arrives, or a mode that changes, inside the high phase of the clock. Only then do the one-stage and two-stage paths give different results. The bench therefore drives its inputs at two points in every cycle: shortly after the falling edge and shortly after the rising edge. Directed cases place a request rise, a request drop, a mode switch and a reset release in the high phase. Random cycles re-draw the inputs at both points and are compared against an edge-accurate model.

// File: rtl/rdy_sync_pkg.sv
package rdy_sync_pkg;
   typedef enum logic {
      SYNC_TWO_STAGE = 1'b0,
      SYNC_ONE_STAGE = 1'b1
   } sync_mode_e;
endpackage

// File: rtl/rdy_qualify.sv
module rdy_qualify #(
   parameter int N_REQ           = 2,
   parameter bit GATE_ACTIVE_LOW = 1'b1
) (
   input  logic [N_REQ-1:0] bus_rdy,
   input  logic [N_REQ-1:0] bus_gate,
   output logic             merged
);
   logic [N_REQ-1:0] hit;

   for (genvar g = 0; g < N_REQ; g++) begin : g_bus
      if (GATE_ACTIVE_LOW) begin : g_low
         assign hit[g] = bus_rdy[g] & ~bus_gate[g];
      end else begin : g_high
         assign hit[g] = bus_rdy[g] & bus_gate[g];
      end
   end

   assign merged = |hit;
endmodule

// File: rtl/rdy_stage_rise.sv
module rdy_stage_rise (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
   end
endmodule

// File: rtl/rdy_stage_fall.sv
module rdy_stage_fall
   import rdy_sync_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  sync_mode_e mode,
   input  logic       merged,
   input  logic       stage1,
   output logic       q
);
   logic d;

   always_comb begin
      case (mode)
         SYNC_ONE_STAGE: d = merged;
         default:        d = stage1 & merged;
      endcase
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
   end
endmodule

// File: rtl/rdy_sync_dual.sv
module rdy_sync_dual
   import rdy_sync_pkg::*;
#(
   parameter int N_REQ           = 2,
   parameter bit GATE_ACTIVE_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] bus_rdy,
   input  logic [N_REQ-1:0] bus_gate,
   input  logic             mode_sync,
   output logic             ready_o
);
   localparam int MAX_REQ = 32;

   if (N_REQ < 1 || N_REQ > MAX_REQ) begin : g_bad_n_req
      $error("rdy_sync_dual: N_REQ out of range");
   end

   logic       merged;
   logic       stage1_q;
   sync_mode_e mode;

   assign mode = sync_mode_e'(mode_sync);

   rdy_qualify #(
      .N_REQ          (N_REQ),
      .GATE_ACTIVE_LOW(GATE_ACTIVE_LOW)
   ) u_qual (
      .bus_rdy (bus_rdy),
      .bus_gate(bus_gate),
      .merged  (merged)
   );

   rdy_stage_rise u_s1 (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (merged),
      .q    (stage1_q)
   );

   rdy_stage_fall u_s2 (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .merged(merged),
      .stage1(stage1_q),
      .q     (ready_o)
   );
endmodule

// File: rtl/rdy_sync_dual_chk.sv
module rdy_sync_dual_chk #(
   parameter int N_REQ           = 2,
   parameter bit GATE_ACTIVE_LOW = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_REQ-1:0] bus_rdy,
   input logic [N_REQ-1:0] bus_gate,
   input logic             mode_sync,
   input logic             stage1_q,
   input logic             ready_o
);
   logic req;
   assign req = GATE_ACTIVE_LOW ? |(bus_rdy & ~bus_gate) : |(bus_rdy & bus_gate);

   // R4: a false request clears READY at the falling edge
   assert_drop_direct_R4: assert property (@(negedge clk) disable iff (!rst_n)
      !req |=> !ready_o);

   // R5: one-stage mode follows the request edge for edge
   assert_one_stage_R5: assert property (@(negedge clk) disable iff (!rst_n)
      mode_sync |=> (ready_o == $past(req)));

   // R3: two-stage mode cannot rise without stage one
   assert_needs_stage1_R3: assert property (@(negedge clk) disable iff (!rst_n)
      (!mode_sync && !stage1_q) |=> !ready_o);

   // R3: stage one tracks the request at rising edges
   assert_stage1_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (stage1_q == $past(req)));

   // R8: reset holds READY low
   assert_reset_low_R8: assert property (@(negedge clk)
      !rst_n |-> !ready_o);
endmodule

bind rdy_sync_dual rdy_sync_dual_chk #(
   .N_REQ          (N_REQ),
   .GATE_ACTIVE_LOW(GATE_ACTIVE_LOW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_rdy  (bus_rdy),
   .bus_gate (bus_gate),
   .mode_sync(mode_sync),
   .stage1_q (stage1_q),
   .ready_o  (ready_o)
);

// File: tb/rdy_sync_dual_tb.sv
`timescale 1ns/1ps
module rdy_sync_dual_tb;
   localparam int N = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] bus_rdy = '0;
   logic [N-1:0] bus_gate = '0;
   logic         mode_sync = 1'b1;
   logic         ready_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic m1, m2;

   always #2.5 clk = ~clk;

   rdy_sync_dual #(.N_REQ(N)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_rdy  (bus_rdy),
      .bus_gate (bus_gate),
      .mode_sync(mode_sync),
      .ready_o  (ready_o)
   );

   function automatic logic want_req(logic [N-1:0] r, logic [N-1:0] g);
      logic any = 1'b0;
      for (int i = 0; i < N; i++) if (r[i] && !g[i]) any = 1'b1;
      return any;
   endfunction

   function automatic logic want_fall(logic md, logic s1, logic rq);
      return md ? rq : (s1 && rq);
   endfunction

   // edge-accurate reference built from R3/R4/R5/R8
   always @(posedge clk or negedge rst_n)
      if (!rst_n) m1 <= 1'b0;
      else        m1 <= want_req(bus_rdy, bus_gate);

   always @(negedge clk or negedge rst_n)
      if (!rst_n) m2 <= 1'b0;
      else        m2 <= want_fall(mode_sync, m1, want_req(bus_rdy, bus_gate));

   task automatic check(logic exp, string req, string what);
      n_chk++;
      if (ready_o !== exp) begin
         n_bad++;
         $display("FAIL %s %s: ready_o=%b expected %b at %0t", req, what, ready_o, exp, $time);
      end
   endtask

   task automatic hi_mid(); @(posedge clk); #1; endtask
   task automatic lo_mid(); @(negedge clk); #1; endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: ready_o=%b expected completion", ready_o);
         finish_run();
      end
   end

   initial begin
      logic prev;
      void'($urandom(32'h5EED_0042));
      repeat (3) lo_mid();
      check(1'b0, "R8", "in reset");
      rst_n = 1'b1;

      // R3 two-stage rise, bus 0, request placed after falling edge
      mode_sync = 1'b0; bus_rdy = 2'b01; bus_gate = 2'b00;
      hi_mid(); check(1'b0, "R3", "stage1 only");
      lo_mid(); check(1'b1, "R3", "after stage2");
      // R4 direct drop during high phase
      hi_mid(); bus_rdy = 2'b00;
      lo_mid(); check(1'b0, "R4", "direct drop");
      // R3/R2 request from bus 1 arriving in high phase
      hi_mid(); bus_rdy = 2'b10;
      lo_mid(); check(1'b0, "R3", "late arrival blocked");
      lo_mid(); check(1'b1, "R2", "bus1 alone");
      // R1 masking
      bus_gate = 2'b10;
      lo_mid(); check(1'b0, "R1", "gate masks bus1");
      bus_rdy = 2'b11; bus_gate = 2'b11;
      lo_mid(); lo_mid(); check(1'b0, "R1", "both masked");
      // R5 one-stage mode
      mode_sync = 1'b1; bus_rdy = 2'b00; bus_gate = 2'b00;
      lo_mid(); check(1'b0, "R5", "idle");
      hi_mid(); bus_rdy = 2'b01;
      lo_mid(); check(1'b1, "R5", "same-cycle rise");
      hi_mid(); bus_rdy = 2'b00;
      lo_mid(); check(1'b0, "R5", "same-cycle drop");
      // R7 switch to two-stage in the high phase
      hi_mid(); bus_rdy = 2'b01; mode_sync = 1'b0;
      lo_mid(); check(1'b0, "R7", "new mode applied");
      hi_mid(); check(1'b0, "R6", "steady over rising edge");
      lo_mid(); check(1'b1, "R7", "two-stage completes");
      // R7 switch back to one-stage: drop then rise in one high phase
      hi_mid(); bus_rdy = 2'b00;
      lo_mid(); check(1'b0, "R4", "drop");
      hi_mid(); bus_rdy = 2'b10; mode_sync = 1'b1;
      lo_mid(); check(1'b1, "R7", "one-stage immediate");
      // R8 reset mid-run, release in high phase with request held
      hi_mid(); rst_n = 1'b0; mode_sync = 1'b0;
      #0.5; check(1'b0, "R8", "async clear");
      lo_mid(); hi_mid(); rst_n = 1'b1;
      lo_mid(); check(1'b0, "R8", "stage1 cleared");
      lo_mid(); check(1'b1, "R8", "recovers");

      // random phase
      for (int k = 0; k < 2000; k++) begin
         bus_rdy   = N'($urandom);
         bus_gate  = ($urandom % 4 == 0) ? N'($urandom) : '0;
         mode_sync = 1'($urandom);
         prev = ready_o;
         hi_mid();
         check(prev, "R6", "rand stable over rising edge");
         check(m2, "R5", "rand model after rising edge");
         if ($urandom % 2 == 0) bus_rdy = N'($urandom);
         if ($urandom % 4 == 0) mode_sync = ~mode_sync;
         lo_mid();
         check(m2, mode_sync ? "R5" : "R3", "rand model after falling edge");
      end

      done = 1'b1;
      finish_run();
   end
endmodule